// File: doc/BRIEF.md
# Single-Source Interrupt Redirect Unit

This unit sits next to the program counter of a small processor and turns one push-button interrupt into a pair of program-counter overrides. The button level is asynchronous to the program. It is first brought into the clock domain, and by default only its rising edge counts as a request. When a request is accepted, the PC of the current cycle is copied into a single link register. In the following cycle the unit drives a load strobe together with a fixed handler address. When the handler raises its return strobe, the unit drives the saved address back onto the PC.

There is one link register and no vector table, so interrupts cannot nest. While the handler runs, a new request is not taken. It is held as pending and served right after the return. The handler address, the PC width, the synchroniser depth and the choice between edge and level detection are all parameters.

Top module: `irq_redirect_unit`

## Requirements
- R1: When a request is accepted, the link register takes the value of `pc_cur` sampled at that clock edge. The exception is acceptance in the cycle where a return load is being driven: the link then keeps its value, because the PC is being overwritten with that same address.
- R2: In the cycle after a request is accepted, `pc_load` is 1 and `pc_value` equals `HANDLER_ADDR`.
- R3: A return strobe sampled while the handler is active makes `pc_load` 1 in the next cycle, with `pc_value` equal to the link register.
- R4: Each redirect and each return drives `pc_load` high for exactly one cycle. When `pc_load` is 0, `pc_value` is 0.
- R5: While the handler is active, no new redirect is issued and the link register does not change.
- R6: A request that arrives while the handler is active is latched as pending. It is accepted in the cycle of the return load, so the handler address is loaded in the cycle right after the return address. The link is kept, so the next return gives the same address again.
- R7: A return strobe seen while no handler is active is ignored and produces no load.
- R8: After reset the unit is idle. `pc_load` is 0, no handler is active, nothing is pending and the link register is 0.
- R9: In edge mode (`EDGE_MODE`=1), a button held high gives exactly one request. In level mode, a held button requests again after every return.
- R10: A rising button level needs `SYNC_STAGES` clock edges to pass the synchroniser and one more edge to be accepted. With the defaults, `pc_load` therefore rises after the third clock edge that follows the button change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_btn | input | 1 | Raw push-button interrupt level |
| pc_cur | input | PC_W | Program counter of the current cycle |
| irq_ret | input | 1 | Return-from-handler strobe |
| pc_load | output | 1 | PC override enable, one cycle per event |
| pc_value | output | PC_W | Override address (handler or restored PC), 0 when idle |

## Verification
A corrupted link register shows up only at a return. It appears as a wrong `pc_value` in the single cycle after the return strobe, which may be many cycles after the capture. For that reason every return value is compared with an address the bench recorded itself. A stuck in-handler or pending flag appears at the ports as a missing redirect, or as an extra redirect, in the cycle after a return or after a synchronised button edge. Because of this, the output is compared with the reference model on every clock, and not only at scenario ends.

// File: rtl/irq_redirect_pkg.sv
package irq_redirect_pkg;

   typedef enum logic [1:0] {
      LD_NONE    = 2'd0,
      LD_HANDLER = 2'd1,
      LD_RETURN  = 2'd2
   } ld_kind_e;

endpackage

// File: rtl/irq_req_cond.sv
module irq_req_cond #(
   parameter int SYNC_STAGES = 2,
   parameter bit EDGE_MODE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_async,
   output logic req_evt
);

   logic req_sync;

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("irq_req_cond: SYNC_STAGES must be 0..4");
   end

   if (SYNC_STAGES == 0) begin : g_nosync
      assign req_sync = req_async;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q <= '0;
         end else begin
            sync_q[0] <= req_async;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               sync_q[i] <= sync_q[i-1];
            end
         end
      end
      assign req_sync = sync_q[SYNC_STAGES-1];
   end

   if (EDGE_MODE) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= req_sync;
      end
      assign req_evt = req_sync & ~prev_q;

      AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         req_evt |=> !req_evt); // R9
   end else begin : g_level
      assign req_evt = req_sync;
   end

endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
   import irq_redirect_pkg::*;
#(
   parameter int PC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_evt,
   input  logic            ret_strobe,
   input  logic [PC_W-1:0] pc_cur,
   output ld_kind_e        ld_kind,
   output logic [PC_W-1:0] link_q
);

   logic in_hdl_q;
   logic pend_q;
   logic red_q;
   logic ret_q;
   logic take;

   assign take = !in_hdl_q && (req_evt || pend_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_hdl_q <= 1'b0;
         pend_q   <= 1'b0;
         red_q    <= 1'b0;
         ret_q    <= 1'b0;
         link_q   <= '0;
      end else begin
         red_q <= take;
         ret_q <= in_hdl_q && ret_strobe;
         if (take)            in_hdl_q <= 1'b1;
         else if (ret_strobe) in_hdl_q <= 1'b0;
         if (take)                      pend_q <= 1'b0;
         else if (req_evt && in_hdl_q)  pend_q <= 1'b1;
         if (take && !ret_q)            link_q <= pc_cur;
      end
   end

   always_comb begin
      if (red_q)      ld_kind = LD_HANDLER;
      else if (ret_q) ld_kind = LD_RETURN;
      else            ld_kind = LD_NONE;
   end

   AST_REDIRECT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (red_q && in_hdl_q)); // R2
   AST_LINK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !ret_q) |=> (link_q == $past(pc_cur))); // R1
   AST_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
      (in_hdl_q && !ret_strobe) |=> (in_hdl_q && !red_q && $stable(link_q))); // R5
   AST_PEND_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_q && pend_q) |=> red_q); // R6
   AST_RET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_hdl_q && ret_strobe) |=> !ret_q); // R7
   AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(red_q && ret_q)); // R4
   AST_RED_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      red_q |=> !red_q); // R4

endmodule

// File: rtl/pc_override_mux.sv
module pc_override_mux
   import irq_redirect_pkg::*;
#(
   parameter int              PC_W         = 16,
   parameter logic [PC_W-1:0] HANDLER_ADDR = '0
) (
   input  ld_kind_e        ld_kind,
   input  logic [PC_W-1:0] link_q,
   output logic            pc_load,
   output logic [PC_W-1:0] pc_value
);

   always_comb begin
      unique case (ld_kind)
         LD_HANDLER: begin
            pc_load  = 1'b1;
            pc_value = HANDLER_ADDR;
         end
         LD_RETURN: begin
            pc_load  = 1'b1;
            pc_value = link_q;
         end
         default: begin
            pc_load  = 1'b0;
            pc_value = '0;
         end
      endcase
   end

endmodule

// File: rtl/irq_redirect_unit.sv
module irq_redirect_unit
   import irq_redirect_pkg::*;
#(
   parameter int              PC_W         = 16,
   parameter logic [PC_W-1:0] HANDLER_ADDR = 16'h0100,
   parameter int              SYNC_STAGES  = 2,
   parameter bit              EDGE_MODE    = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            irq_btn,
   input  logic [PC_W-1:0] pc_cur,
   input  logic            irq_ret,
   output logic            pc_load,
   output logic [PC_W-1:0] pc_value
);

   if (PC_W < 2 || PC_W > 64) begin : g_bad_width
      $error("irq_redirect_unit: PC_W must be 2..64");
   end

   logic            req_evt;
   ld_kind_e        ld_kind;
   logic [PC_W-1:0] link_q;

   irq_req_cond #(
      .SYNC_STAGES (SYNC_STAGES),
      .EDGE_MODE   (EDGE_MODE)
   ) u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_async (irq_btn),
      .req_evt   (req_evt)
   );

   irq_redirect_ctrl #(
      .PC_W (PC_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_evt    (req_evt),
      .ret_strobe (irq_ret),
      .pc_cur     (pc_cur),
      .ld_kind    (ld_kind),
      .link_q     (link_q)
   );

   pc_override_mux #(
      .PC_W         (PC_W),
      .HANDLER_ADDR (HANDLER_ADDR)
   ) u_mux (
      .ld_kind  (ld_kind),
      .link_q   (link_q),
      .pc_load  (pc_load),
      .pc_value (pc_value)
   );

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_load |-> (pc_value == '0)); // R4
   AST_RET_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_kind == LD_RETURN) |-> (pc_load && pc_value == link_q)); // R3

endmodule

// File: tb/irq_redirect_unit_tb.sv
module irq_redirect_unit_tb;

   localparam int              PC_W  = 16;
   localparam logic [PC_W-1:0] HADDR = 16'h0100;
   localparam int              SYNC  = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            irq_btn = 1'b0;
   logic [PC_W-1:0] pc_cur = 16'h1000;
   logic            irq_ret = 1'b0;
   logic            pc_load;
   logic [PC_W-1:0] pc_value;

   int checks = 0;
   int errors = 0;
   int cnt_red = 0;
   int cnt_ret = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_redirect_unit #(
      .PC_W (PC_W), .HANDLER_ADDR (HADDR), .SYNC_STAGES (SYNC), .EDGE_MODE (1'b1)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .irq_btn (irq_btn), .pc_cur (pc_cur),
      .irq_ret (irq_ret), .pc_load (pc_load), .pc_value (pc_value)
   );

   // behavioural reference model
   bit              sq[$];
   bit              m_prev, m_in, m_pend, m_red, m_ret;
   logic [PC_W-1:0] m_link;

   always @(posedge clk) begin
      if (!rst_n) begin
         sq = {};
         for (int i = 0; i < SYNC; i++) sq.push_back(1'b0);
         m_prev = 0; m_in = 0; m_pend = 0; m_red = 0; m_ret = 0; m_link = '0;
      end else begin
         bit raw, evt, take, n_ret;
         raw = sq[SYNC-1];
         evt = raw && !m_prev;
         m_prev = raw;
         void'(sq.pop_back());
         sq.push_front(irq_btn);
         take  = !m_in && (evt || m_pend);
         n_ret = m_in && irq_ret;
         if (take) begin
            if (!m_ret) m_link = pc_cur;
            m_in = 1; m_pend = 0;
         end else begin
            if (evt && m_in) m_pend = 1;
            if (irq_ret) m_in = 0;
         end
         m_red = take;
         m_ret = n_ret;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic            e_ld;
         logic [PC_W-1:0] e_val;
         string           tag;
         e_ld  = m_red || m_ret;
         e_val = m_red ? HADDR : (m_ret ? m_link : '0);
         tag   = m_red ? "R2" : (m_ret ? "R3" : "R4");
         check(pc_load == e_ld, tag, "pc_load", pc_load, e_ld);
         check(pc_value == e_val, tag, "pc_value", pc_value, e_val);
         if (pc_load && pc_value == HADDR) cnt_red++;
         else if (pc_load) cnt_ret++;
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
      pc_cur = pc_cur + 16'd4;
   endtask

   task automatic wait_redirect(output logic [PC_W-1:0] saved);
      saved = '0;
      for (int i = 0; i < 20; i++) begin
         tick();
         @(negedge clk);
         if (pc_load && pc_value == HADDR) begin
            saved = pc_cur - 16'd4;
            break;
         end
      end
   endtask

   initial begin
      #40000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [PC_W-1:0] saved1, saved2;
      repeat (3) tick();
      @(negedge clk);
      check(pc_load == 1'b0 && pc_value == '0, "R8", "idle in reset", pc_load, 0);
      rst_n = 1'b1;
      repeat (3) tick();
      irq_ret = 1'b1; tick(); irq_ret = 1'b0; tick();
      @(negedge clk);
      check(cnt_ret == 0, "R8", "no return after reset", cnt_ret, 0);

      // basic redirect with synchroniser latency
      tick(); irq_btn = 1'b1;
      repeat (2) tick();
      @(negedge clk);
      check(pc_load == 1'b0, "R10", "no early redirect", pc_load, 0);
      tick();
      @(negedge clk);
      check(pc_load == 1'b1 && pc_value == HADDR, "R10", "redirect after 3 edges", pc_value, HADDR);
      saved1 = pc_cur - 16'd4;
      repeat (12) tick();
      check(cnt_red == 1, "R9", "held button gives one request", cnt_red, 1);
      irq_btn = 1'b0;
      tick(); irq_ret = 1'b1; tick(); irq_ret = 1'b0;
      @(negedge clk);
      check(pc_load && pc_value == saved1, "R1", "restored address", pc_value, saved1);
      repeat (6) tick();
      check(cnt_red == 1, "R9", "no retrigger after return", cnt_red, 1);

      // return strobes outside the handler
      cnt_red = 0; cnt_ret = 0;
      irq_ret = 1'b1; repeat (3) tick(); irq_ret = 1'b0; repeat (3) tick();
      @(negedge clk);
      check(cnt_ret + cnt_red == 0, "R7", "stray returns ignored", cnt_ret + cnt_red, 0);

      // request during handler becomes pending
      cnt_red = 0; cnt_ret = 0;
      irq_btn = 1'b1;
      wait_redirect(saved2);
      irq_btn = 1'b0; repeat (3) tick();
      irq_btn = 1'b1; repeat (3) tick();
      irq_btn = 1'b0; repeat (8) tick();
      check(cnt_red == 1, "R5", "no nested redirect", cnt_red, 1);
      irq_ret = 1'b1; tick(); irq_ret = 1'b0;
      @(negedge clk);
      check(pc_load && pc_value == saved2, "R3", "return value", pc_value, saved2);
      tick();
      @(negedge clk);
      check(pc_load && pc_value == HADDR, "R6", "pending served next cycle", pc_value, HADDR);
      repeat (4) tick();
      irq_ret = 1'b1; tick(); irq_ret = 1'b0;
      @(negedge clk);
      check(pc_load && pc_value == saved2, "R6", "link kept across pending", pc_value, saved2);
      tick();
      @(negedge clk);
      check(!pc_load, "R4", "single-cycle return load", pc_load, 0);

      // return strobe together with a fresh button edge
      irq_btn = 1'b1;
      wait_redirect(saved1);
      irq_btn = 1'b0; repeat (2) tick();
      irq_btn = 1'b1; tick(); tick(); irq_ret = 1'b1; tick(); irq_ret = 1'b0;
      repeat (10) tick();
      irq_btn = 1'b0;
      irq_ret = 1'b1; tick(); irq_ret = 1'b0;
      repeat (6) tick();
      check(cnt_red == 4, "R6", "redirect count after overlap", cnt_red, 4);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule